// File: doc/BRIEF.md
# Priority-Masked Port Shedding Sequencer

This block gives a multi-port power controller a quick way to drop load. Each port has a host-set priority bit. When the active-low shed request input falls, every port that is both powered and low priority is switched off. The turn-offs happen one at a time, with a fixed number of clock cycles between them, so the supply sees a series of small steps instead of one large drop. The whole sequence finishes inside a fixed latency budget.

A port switched off this way also loses its detection and classification enables. It stays dark until the host sets those enables again and then powers the port up.

Each port also has its own active-low hardware kill input. This input removes power from the port in the same cycle it is asserted, and it also clears the port's enables.

The block keeps the power, detection-enable and classification-enable state for each port. Host strobes set the enables and request power-up. Register access and gate drive sit outside the block. The kill inputs and host strobes are assumed to be synchronous to `clk`. The shed request may be asynchronous.

Top module: `port_shed_seq`

## Requirements
- R1: Only ports whose `prio_low_i` bit is 1 and that are powered are switched off by a shed sequence. Ports whose bit is 0 keep power and enables.
- R2: A shed request passes through a two-flop synchronizer. The first turn-off appears at the clock edge four edges after the request goes low. Every eligible port is off within LATENCY cycles of the request.
- R3: Successive turn-offs in one sequence are exactly STAGGER cycles apart, and never closer.
- R4: A port switched off by shedding has its detection enable and classification enable cleared at that edge.
- R5: A power-up strobe on `on_set_i[i]` takes effect only while `det_en_o[i]` is 1. A strobe on `en_set_i[i]` sets both enables at the next edge.
- R6: While `hw_shdn_n_i[i]` is 0, `port_pwr_o[i]` is 0 in that same cycle and both enables are cleared. After release, the port stays off.
- R7: Ports are switched off in ascending index order. A port that is unpowered or high priority when its turn comes is skipped without using a stagger slot.
- R8: A port that is powered up after a sequence has started is not switched off by that sequence.
- R9: Shedding acts only on the falling edge of the request. Holding the request low does not shed ports powered later, and a new falling edge while a sequence runs is ignored.
- R10: After reset, all ports are unpowered, all enables are 0, and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| shed_req_n_i | input | 1 | Active-low shed request, asynchronous |
| prio_low_i | input | NPORT | 1 = port is low priority (sheddable) |
| hw_shdn_n_i | input | NPORT | Active-low per-port hardware kill |
| en_set_i | input | NPORT | Host strobe: set detection and classification enables |
| on_set_i | input | NPORT | Strobe: power the port up if detection is enabled |
| port_pwr_o | output | NPORT | Port power state |
| det_en_o | output | NPORT | Detection enable per port |
| cls_en_o | output | NPORT | Classification enable per port |

## Verification
The hardest case to reach is a sequence that has already started and is then disturbed. In the test, a port that was shed early is brought back up, and a port that was off at the start is powered up, both between two stagger slots. The stimulus drops the request and counts cycles from that drop. It then issues the enable and power-up strobes at a fixed offset that falls between the first and second turn-off. The scoreboard confirms that only the ports captured at the start go dark, each at its exact expected cycle.

// File: rtl/shed_pkg.sv
package shed_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/shed_req_sync.sv
module shed_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], req_n_i};
  end

  // Falling edge seen on the synchronized copy.
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/shed_port_cell.sv
module shed_port_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_shdn_n_i,
  input  logic en_set_i,
  input  logic on_set_i,
  input  logic shed_i,
  output logic pwr_o,
  output logic det_en_o,
  output logic cls_en_o
);
  logic pwr_q, det_q, cls_q;
  logic kill;

  assign kill = !hw_shdn_n_i || shed_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      det_q <= 1'b0;
      cls_q <= 1'b0;
    end else if (kill) begin
      pwr_q <= 1'b0;
      det_q <= 1'b0;
      cls_q <= 1'b0;
    end else begin
      if (en_set_i) begin
        det_q <= 1'b1;
        cls_q <= 1'b1;
      end
      if (on_set_i && det_q) pwr_q <= 1'b1;
    end
  end

  // The hardware kill acts in the same cycle.
  assign pwr_o    = pwr_q & hw_shdn_n_i;
  assign det_en_o = det_q;
  assign cls_en_o = cls_q;

  assert_shed_clears_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shed_i |=> (!det_q && !cls_q));
  assert_kill_holds_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_shdn_n_i |=> (!pwr_q && !det_q));
  assert_power_needs_det_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> $past(det_q));
endmodule

// File: rtl/shed_scheduler.sv
module shed_scheduler
  import shed_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int STAGGER = 110,
  parameter int LATENCY = 1300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NPORT-1:0] cand_i,
  input  logic [NPORT-1:0] live_i,
  output logic [NPORT-1:0] shed_o
);
  localparam int GW = $clog2(STAGGER + 1);
  localparam int EW = $clog2(LATENCY + 1);

  seq_state_e       state_q;
  logic [NPORT-1:0] target_q;
  logic [GW-1:0]    gap_q;
  logic [NPORT-1:0] avail, pick;
  logic             fire;

  // Lowest-index port still captured and still powered.
  assign avail  = target_q & live_i;
  assign pick   = avail & (~avail + 1'b1);
  assign fire   = (state_q == SEQ_RUN) && (gap_q == '0) && (|avail);
  assign shed_o = fire ? pick : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      target_q <= '0;
      gap_q    <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i) begin
        state_q  <= SEQ_RUN;
        target_q <= cand_i;
        gap_q    <= '0;
      end
    end else begin
      target_q <= avail & ~shed_o;
      if (fire)              gap_q <= GW'(STAGGER - 1);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
      if ((avail & ~shed_o) == '0) state_q <= SEQ_IDLE;
    end
  end

  // Checking state: spacing since last turn-off, time since sequence start.
  logic [GW-1:0] since_q;
  logic [EW-1:0] elapsed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q   <= GW'(STAGGER);
      elapsed_q <= '0;
    end else begin
      if (|shed_o)                   since_q <= GW'(1);
      else if (since_q < GW'(STAGGER)) since_q <= since_q + 1'b1;
      if (state_q == SEQ_IDLE)       elapsed_q <= '0;
      else if (elapsed_q < EW'(LATENCY)) elapsed_q <= elapsed_q + 1'b1;
    end
  end

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|shed_o) |-> (since_q >= GW'(STAGGER)));
  assert_one_at_a_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shed_o));
  assert_within_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN) |-> (elapsed_q < EW'(LATENCY)));
endmodule

// File: rtl/port_shed_seq.sv
module port_shed_seq #(
  parameter int NPORT   = 4,
  parameter int STAGGER = 110,
  parameter int LATENCY = 1300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shed_req_n_i,
  input  logic [NPORT-1:0] prio_low_i,
  input  logic [NPORT-1:0] hw_shdn_n_i,
  input  logic [NPORT-1:0] en_set_i,
  input  logic [NPORT-1:0] on_set_i,
  output logic [NPORT-1:0] port_pwr_o,
  output logic [NPORT-1:0] det_en_o,
  output logic [NPORT-1:0] cls_en_o
);
  localparam int SYNC_STAGES = 2;

  generate
    if (NPORT * STAGGER > LATENCY || STAGGER < 4) begin : g_bad_cfg
      initial $error("port_shed_seq: NPORT*STAGGER exceeds LATENCY or STAGGER < 4");
    end
  endgenerate

  logic             req_fall;
  logic [NPORT-1:0] shed;

  shed_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n_i (shed_req_n_i),
    .fall_o  (req_fall)
  );

  shed_scheduler #(.NPORT(NPORT), .STAGGER(STAGGER), .LATENCY(LATENCY)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (req_fall),
    .cand_i  (port_pwr_o & prio_low_i),
    .live_i  (port_pwr_o),
    .shed_o  (shed)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    shed_port_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_shdn_n_i (hw_shdn_n_i[i]),
      .en_set_i    (en_set_i[i]),
      .on_set_i    (on_set_i[i]),
      .shed_i      (shed[i]),
      .pwr_o       (port_pwr_o[i]),
      .det_en_o    (det_en_o[i]),
      .cls_en_o    (cls_en_o[i])
    );
  end

  assert_low_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shed & ~prio_low_i) == '0);
  assert_shed_hits_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shed & ~port_pwr_o) == '0);
endmodule

// File: tb/sim_port_shed_seq.sv
module sim_port_shed_seq;
  localparam int N = 4;
  localparam int S = 110;
  localparam int L = 1300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic [N-1:0] prio_low = 4'b1011;
  logic [N-1:0] shdn_n = '1;
  logic [N-1:0] en_set = '0;
  logic [N-1:0] on_set = '0;
  logic [N-1:0] pwr, det, cls;

  always #2.5 clk = ~clk;

  port_shed_seq #(.NPORT(N), .STAGGER(S), .LATENCY(L)) u0 (
    .clk(clk), .rst_n(rst_n), .shed_req_n_i(req_n), .prio_low_i(prio_low),
    .hw_shdn_n_i(shdn_n), .en_set_i(en_set), .on_set_i(on_set),
    .port_pwr_o(pwr), .det_en_o(det), .cls_en_o(cls));

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  typedef struct { int port; int at; } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en(input logic [N-1:0] m);
    en_set = m; @(negedge clk); en_set = '0;
  endtask

  task automatic pulse_on(input logic [N-1:0] m);
    on_set = m; @(negedge clk); on_set = '0;
  endtask

  task automatic push_shed(input int port, input int at);
    exp_t e;
    e.port = port; e.at = at;
    q.push_back(e);
  endtask

  // Monitor: every observed turn-off must match the next expected one.
  logic [N-1:0] prev = '0;
  always @(posedge clk) begin
    #1;
    for (int p = 0; p < N; p++) begin
      if (mon_en && prev[p] && !pwr[p]) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected turn-off", p, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(p == e.port, "R7 shed order", p, e.port);
          chk(cyc == e.at, "R3 shed timing", cyc, e.at);
        end
      end
    end
    prev = pwr;
  end

  initial begin
    int c;
    tick(3);
    chk(pwr == '0, "R10 reset power", pwr, 0);
    chk(det == '0, "R10 reset det", det, 0);
    chk(cls == '0, "R10 reset cls", cls, 0);
    rst_n = 1'b1;
    tick(2);

    // R5: power-up refused while detection is off.
    pulse_on(4'b0001);
    tick(2);
    chk(pwr == '0, "R5 on without enable", pwr, 0);
    pulse_en('1);
    chk(det == '1 && cls == '1, "R5 enables set", {det, cls}, 8'hFF);
    pulse_on('1);
    chk(pwr == '1, "R5 power up", pwr, 15);

    // R1/R2/R3/R7: ports 0,1,3 low priority; port 2 high skipped.
    mon_en = 1'b1;
    c = cyc;
    req_n = 1'b0;
    push_shed(0, c + 4);
    push_shed(1, c + 4 + S);
    push_shed(3, c + 4 + 2 * S);
    tick(L);
    chk(q.size() == 0, "R2 all shed within budget", q.size(), 0);
    chk(pwr == 4'b0100, "R1 high priority kept", pwr, 4);
    chk(det == 4'b0100, "R4 det cleared", det, 4);
    chk(cls == 4'b0100, "R4 cls cleared", cls, 4);

    // R9: request held low; a re-powered port is not shed.
    pulse_en(4'b0001);
    pulse_on(4'b0001);
    tick(3 * S);
    chk(pwr == 4'b0101, "R9 held low no reshed", pwr, 5);
    req_n = 1'b1;
    tick(10);

    // R8/R7: port 3 off at start; port 0 re-enabled after its own shed.
    pulse_en(4'b0010);
    pulse_on(4'b0010);
    c = cyc;
    req_n = 1'b0;
    push_shed(0, c + 4);
    push_shed(1, c + 4 + S);
    while (cyc < c + 20) tick(1);
    pulse_en(4'b1001);
    pulse_on(4'b1001);
    tick(3);
    req_n = 1'b1;         // R9: rise and fall mid-sequence is ignored
    tick(6);
    req_n = 1'b0;
    tick(3 * S);
    chk(q.size() == 0, "R8 expected sheds seen", q.size(), 0);
    chk(pwr == 4'b1101, "R8 late power-up kept", pwr, 13);
    mon_en = 1'b0;
    req_n = 1'b1;
    tick(5);

    // R6: hardware kill on port 2.
    shdn_n = 4'b1011;
    #1;
    chk(pwr[2] == 1'b0, "R6 same-cycle kill", pwr[2], 0);
    tick(2);
    chk(det[2] == 1'b0 && cls[2] == 1'b0, "R6 enables cleared", {det[2], cls[2]}, 0);
    shdn_n = '1;
    pulse_on(4'b0100);
    tick(3);
    chk(pwr[2] == 1'b0, "R6 stays off after release", pwr[2], 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule